// File: doc/BRIEF.md
# Wired-AND Programmable Interconnect Crossbar

This block is the routing fabric that sits between the logic groups of a small programmable-logic array. It gathers every macrocell result, every pad feedback and every dedicated input into one source vector. From that vector it forms a set of output lines, a fixed number for each downstream function group. Which sources reach which output is set by a per-output enable mask.

When a mask enables more than one source, the output carries the AND of them. Every output therefore gives one level of logic at no extra cost, and nothing treats it as a drive conflict. Each source also has a polarity bit that inverts it before it enters the matrix. AND of inverted sources gives NOR, and with an inversion downstream it gives NAND or OR. An output with nothing enabled rests at 1, the AND identity.

The data path has no register, so every source-to-output path has the same depth. The masks and the polarity word sit in flops loaded through a one-word-per-clock write port. A write either replaces one output's mask or replaces the whole polarity word.

Top module: `wand_xbar`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all masks and all polarity bits clear, so after reset every output is 1 for any source value.
- R2: An output whose mask is all zero drives 1 whatever the sources are.
- R3: An output whose mask has exactly one bit set follows that source, inverted when its polarity bit is 1.
- R4: An output whose mask has several bits set equals the AND of the enabled sources after polarity, for every mask value.
- R5: A polarity bit of 1 inverts its source for every output that enables it, so an all-inverted mask gives the NOR of the enabled sources.
- R6: Source index i (bit i of `cfg_data`) is `mc_in[i]` for i < N_MC, then `pin_in` in the next N_PIN positions, then `ded_in` in the last N_DED positions. Output line l of group g is `xb_out[g*N_LINE + l]`.
- R7: Outputs follow source changes with no clock edge in between.
- R8: With `cfg_we`=1 and `cfg_kind`=0, the mask of output `cfg_row` becomes `cfg_data` at the rising edge, and no other mask changes.
- R9: With `cfg_we`=1 and `cfg_kind`=1, the polarity word becomes `cfg_data` at the rising edge; `cfg_row` is ignored and no mask changes.
- R10: A mask write with `cfg_row` >= N_OUT changes no mask and no output.
- R11: Asserting reset after configuration returns the block to the cleared state of R1.
- R12: With `cfg_we`=0, no mask and no polarity bit changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration flops |
| rst_n | input | 1 | Synchronous active-low reset, clears the configuration |
| cfg_we | input | 1 | Write strobe for the configuration |
| cfg_kind | input | 1 | 0: write an output mask, 1: write the polarity word |
| cfg_row | input | ROW_W | Output index for a mask write |
| cfg_data | input | N_SRC | Mask or polarity word to load |
| mc_in | input | N_MC | Macrocell result sources |
| pin_in | input | N_PIN | Pad feedback sources |
| ded_in | input | N_DED | Dedicated input sources |
| xb_out | output | N_OUT | Crossbar lines, N_LINE per group for N_GRP groups |

## Verification
The hardest case to reach from the ports is the full interplay of mask and polarity. One output can mix inverted and true sources, and its value must match for every source combination. The bench uses a reduced size with eight sources, which makes a complete sweep possible. It loads every one of the 256 masks into the last output line. It then gives six rows six different masks and steps through all 256 polarity words, and under each configuration it drives all 256 source values. Row-write isolation and ignored writes are seen the same way: every sweep compares all outputs, including rows that were never written or were targeted by out-of-range indices.

// File: rtl/wand_xbar_pkg.sv
// Shared definitions for the wired-AND crossbar.
// Assumes: a single write port that picks its target with one bit.
package wand_xbar_pkg;

    // Target of a configuration write
    typedef enum logic {
        CFG_ROW_MASK = 1'b0,
        CFG_POLARITY = 1'b1
    } cfg_kind_e;

endpackage

// File: rtl/wand_xbar_cfg.sv
// Configuration store: one enable mask per output plus one polarity word.
// Assumes: synchronous active-low reset; row indices at or above N_OUT
// match no row and are dropped.
module wand_xbar_cfg
    import wand_xbar_pkg::*;
#(
    parameter int N_SRC = 24,
    parameter int N_OUT = 96,
    parameter int ROW_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_kind,
    input  logic [ROW_W-1:0]             cfg_row,
    input  logic [N_SRC-1:0]             cfg_data,
    output logic [N_OUT-1:0][N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]             pol_q
);

    logic mask_wr;
    logic pol_wr;

    // Decode the write target
    always_comb begin
        mask_wr = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_ROW_MASK);
        pol_wr  = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_POLARITY);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_row
        logic             hit;
        logic [N_SRC-1:0] row_q;

        assign hit = mask_wr && (cfg_row == ROW_W'(o));

        // Hold this output's enable mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (hit) begin
                row_q <= cfg_data;
            end
        end

        assign mask_q[o] = row_q;
    end

    // Hold the per-source polarity word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (pol_wr) begin
            pol_q <= cfg_data;
        end
    end

endmodule

// File: rtl/wand_xbar_src_cond.sv
// Source conditioning: gathers the three source groups into one vector
// and applies the per-source polarity.
// Assumes: macrocells in the low indices, then pads, then dedicated inputs.
module wand_xbar_src_cond #(
    parameter int N_MC  = 12,
    parameter int N_PIN = 8,
    parameter int N_DED = 4,
    parameter int N_SRC = N_MC + N_PIN + N_DED
) (
    input  logic [N_MC-1:0]  mc_in,
    input  logic [N_PIN-1:0] pin_in,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_SRC-1:0] pol,
    output logic [N_SRC-1:0] src_cond
);

    logic [N_SRC-1:0] src_raw;

    // Concatenate the sources and invert those flagged by polarity
    always_comb begin
        src_raw  = {ded_in, pin_in, mc_in};
        src_cond = src_raw ^ pol;
    end

endmodule

// File: rtl/wand_xbar_and_row.sv
// One crossbar output: AND over the enabled, polarity-adjusted sources.
// Assumes: a disabled source counts as 1, so an empty mask yields 1.
module wand_xbar_and_row #(
    parameter int N_SRC = 24
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] src,
    output logic             y
);

    // Force disabled sources high, then reduce
    always_comb begin
        y = &(~en | src);
    end

endmodule

// File: rtl/wand_xbar.sv
// Wired-AND programmable interconnect crossbar, top level.
// Assumes: purely combinational data path; configuration loaded one word
// per clock; output line l of group g sits at index g*N_LINE + l.
module wand_xbar
    import wand_xbar_pkg::*;
#(
    parameter int N_MC   = 12,
    parameter int N_PIN  = 8,
    parameter int N_DED  = 4,
    parameter int N_GRP  = 4,
    parameter int N_LINE = 24,
    localparam int N_SRC = N_MC + N_PIN + N_DED,
    localparam int N_OUT = N_GRP * N_LINE,
    localparam int ROW_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [N_SRC-1:0]  cfg_data,
    input  logic [N_MC-1:0]   mc_in,
    input  logic [N_PIN-1:0]  pin_in,
    input  logic [N_DED-1:0]  ded_in,
    output logic [N_OUT-1:0]  xb_out
);

    logic [N_OUT-1:0][N_SRC-1:0] row_mask;
    logic [N_SRC-1:0]            src_pol;
    logic [N_SRC-1:0]            src_cond;

    wand_xbar_cfg #(
        .N_SRC (N_SRC),
        .N_OUT (N_OUT),
        .ROW_W (ROW_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_row  (cfg_row),
        .cfg_data (cfg_data),
        .mask_q   (row_mask),
        .pol_q    (src_pol)
    );

    wand_xbar_src_cond #(
        .N_MC  (N_MC),
        .N_PIN (N_PIN),
        .N_DED (N_DED),
        .N_SRC (N_SRC)
    ) u_src (
        .mc_in    (mc_in),
        .pin_in   (pin_in),
        .ded_in   (ded_in),
        .pol      (src_pol),
        .src_cond (src_cond)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar l = 0; l < N_LINE; l++) begin : g_line
            localparam int IDX = g * N_LINE + l;
            wand_xbar_and_row #(
                .N_SRC (N_SRC)
            ) u_row (
                .en  (row_mask[IDX]),
                .src (src_cond),
                .y   (xb_out[IDX])
            );
        end
    end

endmodule

// File: rtl/wand_xbar_chk.sv
// Property checker for the wired-AND crossbar, bound to every instance.
// Assumes: sees the configuration store and the conditioned sources.
module wand_xbar_chk
    import wand_xbar_pkg::*;
#(
    parameter int N_SRC = 24,
    parameter int N_OUT = 96,
    parameter int ROW_W = 7
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic                         cfg_kind,
    input logic [ROW_W-1:0]             cfg_row,
    input logic [N_SRC-1:0]             cfg_data,
    input logic [N_OUT-1:0][N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]             pol_q,
    input logic [N_SRC-1:0]             cond_src,
    input logic [N_OUT-1:0]             xb_out
);

    logic mask_wr;
    logic pol_wr;
    logic row_ok;

    // Classify the write on the port
    always_comb begin
        mask_wr = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_ROW_MASK);
        pol_wr  = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_POLARITY);
        row_ok  = int'(cfg_row) < N_OUT;
    end

    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && row_ok) |=> (mask_q[$past(cfg_row)] == $past(cfg_data))); // R8

    AST_BAD_ROW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !row_ok) |=> $stable(mask_q)); // R10

    AST_POL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr |=> (pol_q == $past(cfg_data))); // R9

    AST_POL_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr |=> $stable(mask_q)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(mask_q) && $stable(pol_q))); // R12

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        AST_EMPTY_ROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[o] == '0) |-> xb_out[o]); // R2

        AST_SINGLE_SRC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(mask_q[o]) == 1) |-> (xb_out[o] == |(mask_q[o] & cond_src))); // R3
    end

endmodule

bind wand_xbar wand_xbar_chk #(
    .N_SRC (N_SRC),
    .N_OUT (N_OUT),
    .ROW_W (ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_kind (cfg_kind),
    .cfg_row  (cfg_row),
    .cfg_data (cfg_data),
    .mask_q   (row_mask),
    .pol_q    (src_pol),
    .cond_src (src_cond),
    .xb_out   (xb_out)
);

// File: tb/tb_wand_xbar.sv
`timescale 1ns/100ps
// Bench: reduced crossbar (8 sources, 2 groups of 3 lines), exhaustive sweeps.
module tb_wand_xbar;

    localparam int N_MC = 4, N_PIN = 2, N_DED = 2, N_GRP = 2, N_LINE = 3;
    localparam int NS = N_MC + N_PIN + N_DED;
    localparam int NO = N_GRP * N_LINE;
    localparam int RW = $clog2(NO);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic          cfg_kind;
    logic [RW-1:0] cfg_row;
    logic [NS-1:0] cfg_data;
    logic [N_MC-1:0]  mc_in;
    logic [N_PIN-1:0] pin_in;
    logic [N_DED-1:0] ded_in;
    logic [NO-1:0]    xb_out;

    int total = 0;
    int bad   = 0;
    logic [NS-1:0] m_mask [NO];
    logic [NS-1:0] m_pol;

    always #2 clk = ~clk;

    wand_xbar #(
        .N_MC (N_MC), .N_PIN (N_PIN), .N_DED (N_DED),
        .N_GRP (N_GRP), .N_LINE (N_LINE)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_kind (cfg_kind),
        .cfg_row (cfg_row), .cfg_data (cfg_data), .mc_in (mc_in),
        .pin_in (pin_in), .ded_in (ded_in), .xb_out (xb_out)
    );

    // Expected output: 0 if any enabled source, after polarity, is 0
    function automatic logic model(input logic [NS-1:0] m, input logic [NS-1:0] p,
                                   input logic [NS-1:0] s);
        logic r = 1'b1;
        for (int i = 0; i < NS; i++)
            if (m[i] && ((s[i] ^ p[i]) == 1'b0)) r = 1'b0;
        return r;
    endfunction

    function automatic logic [NO-1:0] model_all(input logic [NS-1:0] s);
        logic [NO-1:0] w;
        for (int o = 0; o < NO; o++) w[o] = model(m_mask[o], m_pol, s);
        return w;
    endfunction

    task automatic drive_src(input logic [NS-1:0] s);
        mc_in  = s[N_MC-1:0];
        pin_in = s[N_MC+N_PIN-1:N_MC];
        ded_in = s[NS-1:N_MC+N_PIN];
    endtask

    task automatic chk(input string tag, input logic [NO-1:0] got, input logic [NO-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic k, input logic [RW-1:0] r, input logic [NS-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_row = r; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_data = '0;
        if (k) m_pol = d;
        else if (int'(r) < NO) m_mask[r] = d;
    endtask

    // Drive all source values and compare every output; one check per sweep
    task automatic sweep(input string tag);
        int errs = 0;
        logic [NO-1:0] g1, e1;
        logic [NS-1:0] s1;
        for (int v = 0; v < (1 << NS); v++) begin
            drive_src(v[NS-1:0]);
            #1;
            if (xb_out !== model_all(v[NS-1:0])) begin
                if (errs == 0) begin g1 = xb_out; e1 = model_all(v[NS-1:0]); s1 = v[NS-1:0]; end
                errs++;
            end
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s src=%h got=%b exp=%b", tag, s1, g1, e1);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 1'b0; cfg_row = '0; cfg_data = '0;
        drive_src('0);
        for (int o = 0; o < NO; o++) m_mask[o] = '0;
        m_pol = '0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", xb_out, '1);
        rst_n = 1'b1;
        sweep("R1 after reset");

        // R3: each single source on row 0
        for (int i = 0; i < NS; i++) begin
            wr(1'b0, 3'd0, NS'(1) << i);
            sweep("R3 single source");
        end

        // R6: index order of the source groups, group/line placement
        wr(1'b0, 3'd1, 8'h10);
        @(negedge clk); mc_in = '1; pin_in = 2'b01; ded_in = '0; #1;
        chk("R6 first pad line", {5'b0, xb_out[1]}, 6'd1);
        pin_in = 2'b10; #1;
        chk("R6 first pad low", {5'b0, xb_out[1]}, 6'd0);
        wr(1'b0, 3'd1, 8'h40);
        @(negedge clk); mc_in = '0; pin_in = '0; ded_in = 2'b01; #1;
        chk("R6 first dedicated", {5'b0, xb_out[N_LINE*1-2]}, 6'd1);

        // R4: every mask on the last line of the last group
        for (int m = 0; m < (1 << NS); m++) begin
            wr(1'b0, RW'(NO-1), m[NS-1:0]);
            sweep("R4 mask sweep");
        end

        // R2 and R8: rows never written stay high; only the addressed row moved
        wr(1'b0, 3'd0, 8'h00);
        sweep("R2 empty rows");
        wr(1'b0, 3'd3, 8'h0c);
        sweep("R8 row isolation");

        // R12: strobe low with live write data
        @(negedge clk); cfg_kind = 1'b0; cfg_row = 3'd2; cfg_data = 8'hff;
        @(negedge clk); cfg_kind = 1'b1;
        @(negedge clk); cfg_data = '0;
        sweep("R12 no strobe");

        // R10: out-of-range rows
        wr(1'b0, 3'd6, 8'hff);
        wr(1'b0, 3'd7, 8'h01);
        sweep("R10 bad row");

        // R7: output follows sources inside one clock phase
        wr(1'b0, 3'd0, 8'hff);
        @(negedge clk); drive_src(8'hff); #0.5;
        chk("R7 all high", {5'b0, xb_out[0]}, 6'd1);
        drive_src(8'hfe); #0.5;
        chk("R7 one low", {5'b0, xb_out[0]}, 6'd0);

        // R9: polarity write ignores row and leaves masks
        wr(1'b1, 3'd3, 8'hff);
        @(negedge clk); drive_src(8'h00); #1;
        chk("R9 all-inverted NOR", {5'b0, xb_out[0]}, 6'd1);
        chk("R9 masks kept", xb_out, model_all(8'h00));

        // R5: distinct masks per row, every polarity word
        wr(1'b0, 3'd0, 8'hff); wr(1'b0, 3'd1, 8'h0f); wr(1'b0, 3'd2, 8'hf0);
        wr(1'b0, 3'd3, 8'h81); wr(1'b0, 3'd4, 8'h3c); wr(1'b0, 3'd5, 8'h55);
        for (int p = 0; p < (1 << NS); p++) begin
            wr(1'b1, 3'd0, p[NS-1:0]);
            sweep("R5 polarity sweep");
        end

        // R11: reset after configuration
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int o = 0; o < NO; o++) m_mask[o] = '0;
        m_pol = '0;
        drive_src(8'h00); #1;
        chk("R11 cleared", xb_out, '1);
        sweep("R11 cleared sweep");

        finish_run();
    end

endmodule